// File: doc/BRIEF.md
# Half-Duplex Video Expansion Port

This block sits between the internal video decoder and an external 8-bit digital video device. It carries byte-serial YCbCr 4:2:2 video together with line, frame and field timing. The port works in one direction at a time. As an output it presents the decoder's stream unchanged on the pad side. As an input it takes an external stream and hands it to the internal image-port interface as luma/chroma pairs.

A direction request is a level. It is honoured only at a field boundary, so a field is never split between the two directions. While the port is receiving, or turning around from input to output, its pad drivers are held off by an output-enable. On input, one control selects where timing comes from: either codes embedded in the data (a preamble of all-ones, zero, zero, then a status byte) or the separate sync pins. A second control widens the input path to 16 bits. In that mode luma arrives on the primary lane and alternating chroma on the extension lane, one pair per clock.

Top module: `vexp_port`

## Requirements
- R1: In 8-bit input mode the active bytes arrive in the order Cb, Y, Cr, Y. After each Y byte the image port presents one item, one clock after that byte is sampled. The item pairs that Y with the chroma byte received just before it. `img_c_is_cr` is 0 for Cb and 1 for Cr. Two 8-bit items never appear on consecutive clocks.
- R2: The pad output-enable is high only in output mode. The image port produces items only from data sampled while the port is in input mode.
- R3: The direction (`port_is_input`, 1 = input) changes only at a field edge. At that edge it takes the value of `dir_req` sampled on the same clock, so a request that is withdrawn before the edge has no effect.
- R4: The pad data, hsync, vsync and field outputs always equal the decoder's data, hsync, vsync and field inputs in the same cycle, with no register in between.
- R5: On a switch from output to input, the output-enable falls on the same clock as the direction changes. On a switch from input to output, it rises one clock after the direction changes.
- R6: With embedded timing selected, a status byte that follows the preamble FF, 00, 00 is decoded with F in bit 6, V in bit 5 and H in bit 4. A status byte with H=0 and V=0 opens the active area from the next byte. A status byte with V=1 opens nothing. An FF byte closes the active area.
- R7: With separate sync selected, bytes are active only while `pad_hs_i` and `pad_vs_i` are both low.
- R8: In 16-bit input mode, every active clock yields one item. The item's luma comes from `pad_data_i` and its chroma from `pad_ext_i`. `img_c_is_cr` starts at 0 at the start of the active area and alternates on every item.
- R9: The field edge comes from a change of `dec_fld` in output mode. In input mode with separate sync it comes from a change of `pad_fld_i`. In input mode with embedded timing it comes from a decoded F bit that differs from the previous one.
- R10: During reset the port is in output mode, the output-enable is high and the image port presents no item.
- R11: Each item's `img_fld` is the current field: the last decoded F bit with embedded timing, or `pad_fld_i` with separate sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_req | input | 1 | Requested direction, 1 = input |
| embed_codes | input | 1 | 1 = input timing from embedded codes, 0 = from sync pins |
| wide_in | input | 1 | 1 = 16-bit input path |
| dec_data | input | 8 | Decoder video bytes |
| dec_hs | input | 1 | Decoder line sync |
| dec_vs | input | 1 | Decoder frame sync |
| dec_fld | input | 1 | Decoder field indicator |
| pad_data_i | input | 8 | Incoming primary byte lane |
| pad_ext_i | input | 8 | Incoming extension lane (chroma in 16-bit mode) |
| pad_hs_i | input | 1 | Incoming line sync |
| pad_vs_i | input | 1 | Incoming frame sync |
| pad_fld_i | input | 1 | Incoming field indicator |
| pad_data_o | output | 8 | Outgoing byte lane |
| pad_hs_o | output | 1 | Outgoing line sync |
| pad_vs_o | output | 1 | Outgoing frame sync |
| pad_fld_o | output | 1 | Outgoing field indicator |
| pad_oe | output | 1 | Pad driver enable |
| port_is_input | output | 1 | Current direction, 1 = input |
| img_valid | output | 1 | Image-port item valid |
| img_y | output | 8 | Item luma |
| img_c | output | 8 | Item chroma |
| img_c_is_cr | output | 1 | Item chroma is Cr |
| img_fld | output | 1 | Item field |

## Verification
The two functions that can land on one clock are a change of the direction request and the field edge that applies it. A second such pair is an embedded status byte that both flips F and opens an active area. The bench changes `dir_req` on the very clock that `dec_fld` toggles and expects the switch to happen. It withdraws a request several clocks before a `pad_fld_i` toggle and expects no switch. It also sends an F=1 start code while an output request is pending, and expects the port to turn around with no image item from the area that code would have opened. Output-enable timing around each switch is sampled on the exact clocks given by the requirements.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } dir_e;

  // status byte bit positions after the preamble
  localparam int F_POS = 6;
  localparam int V_POS = 5;
  localparam int H_POS = 4;
  localparam int PRE_LEN = 3;
endpackage

// File: rtl/vexp_code_det.sv
module vexp_code_det import vexp_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  output logic          hit,
  output logic          v_bit,
  output logic          h_bit,
  output logic          fld,
  output logic          fld_edge
);
  logic [DW-1:0]      hist_q [PRE_LEN];
  logic [PRE_LEN-1:0] match;
  logic               fld_q, fld_d;

  for (genvar i = 0; i < PRE_LEN; i++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[i] <= '0;
      else if (i == 0) hist_q[i] <= din;
      else hist_q[i] <= hist_q[(i == 0) ? 0 : i-1];
    end
    if (i == PRE_LEN-1) begin : g_ones
      assign match[i] = (hist_q[i] == '1);
    end else begin : g_zero
      assign match[i] = (hist_q[i] == '0);
    end
  end

  always_comb begin
    hit      = &match;
    v_bit    = din[V_POS];
    h_bit    = din[H_POS];
    fld_edge = hit && (din[F_POS] != fld_q);
    fld_d    = hit ? din[F_POS] : fld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= 1'b0;
    else        fld_q <= fld_d;
  end

  assign fld = fld_q;
endmodule

// File: rtl/vexp_dir_ctl.sv
module vexp_dir_ctl import vexp_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic fld_edge,
  input  logic dir_req,
  output dir_e mode,
  output logic oe
);
  dir_e mode_q, mode_d;
  logic oe_q, oe_d;

  always_comb begin
    mode_d = fld_edge ? dir_e'(dir_req) : mode_q;
    // drivers come on only after a full clock spent in output mode
    oe_d   = (mode_q == DIR_OUT) && (mode_d == DIR_OUT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DIR_OUT;
      oe_q   <= 1'b1;
    end else begin
      mode_q <= mode_d;
      oe_q   <= oe_d;
    end
  end

  assign mode = mode_q;
  assign oe   = oe_q;
endmodule

// File: rtl/vexp_in_pack.sv
module vexp_in_pack #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wide,
  input  logic          embed,
  input  logic [DW-1:0] d_p,
  input  logic [DW-1:0] d_x,
  input  logic          hs,
  input  logic          vs,
  input  logic          sav_go,
  input  logic          fld_cur,
  output logic          vld,
  output logic [DW-1:0] y,
  output logic [DW-1:0] c,
  output logic          c_sel,
  output logic          fld
);
  localparam int PH_W = 2;

  logic            act_q, act_d, act, emit;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [DW-1:0]   hold_q, hold_d, y_q, y_d, c_q, c_d;
  logic            vld_q, vld_d, sel_q, sel_d, fld_q, fld_d;

  always_comb begin
    if (!en)                act_d = 1'b0;
    else if (sav_go)        act_d = 1'b1;
    else if (d_p == '1)     act_d = 1'b0;
    else                    act_d = act_q;
    act    = en && (embed ? (act_q && (d_p != '1)) : (!hs && !vs));
    ph_d   = act ? ph_q + 1'b1 : '0;
    hold_d = (act && !wide && !ph_q[0]) ? d_p : hold_q;
    emit   = act && (wide || ph_q[0]);
    vld_d  = emit;
    y_d    = emit ? d_p : y_q;
    c_d    = emit ? (wide ? d_x : hold_q) : c_q;
    sel_d  = emit ? (wide ? ph_q[0] : ph_q[1]) : sel_q;
    fld_d  = emit ? fld_cur : fld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= '0;
      hold_q <= '0;
      vld_q  <= 1'b0;
      y_q    <= '0;
      c_q    <= '0;
      sel_q  <= 1'b0;
      fld_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      ph_q   <= ph_d;
      hold_q <= hold_d;
      vld_q  <= vld_d;
      y_q    <= y_d;
      c_q    <= c_d;
      sel_q  <= sel_d;
      fld_q  <= fld_d;
    end
  end

  assign vld   = vld_q;
  assign y     = y_q;
  assign c     = c_q;
  assign c_sel = sel_q;
  assign fld   = fld_q;
endmodule

// File: rtl/vexp_port.sv
module vexp_port import vexp_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_req,
  input  logic          embed_codes,
  input  logic          wide_in,
  input  logic [DW-1:0] dec_data,
  input  logic          dec_hs,
  input  logic          dec_vs,
  input  logic          dec_fld,
  input  logic [DW-1:0] pad_data_i,
  input  logic [DW-1:0] pad_ext_i,
  input  logic          pad_hs_i,
  input  logic          pad_vs_i,
  input  logic          pad_fld_i,
  output logic [DW-1:0] pad_data_o,
  output logic          pad_hs_o,
  output logic          pad_vs_o,
  output logic          pad_fld_o,
  output logic          pad_oe,
  output logic          port_is_input,
  output logic          img_valid,
  output logic [DW-1:0] img_y,
  output logic [DW-1:0] img_c,
  output logic          img_c_is_cr,
  output logic          img_fld
);
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  logic       code_hit, code_v, code_h, emb_fld, emb_edge;
  logic       dec_fld_q, pad_fld_q, fld_edge, sav_go, fld_cur;
  dir_e       mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign pad_data_o = dec_data;
  assign pad_hs_o   = dec_hs;
  assign pad_vs_o   = dec_vs;
  assign pad_fld_o  = dec_fld;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      dec_fld_q <= 1'b0;
      pad_fld_q <= 1'b0;
    end else begin
      dec_fld_q <= dec_fld;
      pad_fld_q <= pad_fld_i;
    end
  end

  vexp_code_det #(.DW(DW)) u_det (
    .clk(clk), .rst_n(rst_q_n), .din(pad_data_i), .hit(code_hit),
    .v_bit(code_v), .h_bit(code_h), .fld(emb_fld), .fld_edge(emb_edge)
  );

  always_comb begin
    if (mode == DIR_OUT)  fld_edge = dec_fld ^ dec_fld_q;
    else if (embed_codes) fld_edge = emb_edge;
    else                  fld_edge = pad_fld_i ^ pad_fld_q;
    sav_go  = code_hit && !code_h && !code_v;
    fld_cur = embed_codes ? emb_fld : pad_fld_i;
  end

  vexp_dir_ctl u_dir (
    .clk(clk), .rst_n(rst_q_n), .fld_edge(fld_edge), .dir_req(dir_req),
    .mode(mode), .oe(pad_oe)
  );

  assign port_is_input = (mode == DIR_IN);

  vexp_in_pack #(.DW(DW)) u_pack (
    .clk(clk), .rst_n(rst_q_n), .en(port_is_input), .wide(wide_in),
    .embed(embed_codes), .d_p(pad_data_i), .d_x(pad_ext_i),
    .hs(pad_hs_i), .vs(pad_vs_i), .sav_go(sav_go), .fld_cur(fld_cur),
    .vld(img_valid), .y(img_y), .c(img_c), .c_sel(img_c_is_cr), .fld(img_fld)
  );
endmodule

// File: rtl/vexp_port_chk.sv
module vexp_port_chk (
  input logic clk,
  input logic rst_n,
  input logic pad_oe,
  input logic port_is_input,
  input logic img_valid,
  input logic img_c_is_cr,
  input logic wide_in,
  input logic fld_edge
);
  AST_OE_ONLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> !port_is_input); // R2

  AST_ITEM_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    img_valid |-> $past(port_is_input)); // R2

  AST_DIR_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_is_input != $past(port_is_input)) |-> $past(fld_edge)); // R3

  AST_OE_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_oe) |-> $past(!port_is_input)); // R5

  AST_NARROW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (img_valid && !wide_in && $past(!wide_in)) |-> !$past(img_valid)); // R1

  AST_WIDE_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (img_valid && $past(img_valid) && wide_in && $past(wide_in))
      |-> (img_c_is_cr != $past(img_c_is_cr))); // R8
endmodule

bind vexp_port vexp_port_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .pad_oe(pad_oe), .port_is_input(port_is_input),
  .img_valid(img_valid), .img_c_is_cr(img_c_is_cr), .wide_in(wide_in),
  .fld_edge(fld_edge)
);

// File: tb/test_vexp_port.sv
module test_vexp_port;
  logic clk, rst_n, dir_req, embed_codes, wide_in;
  logic [7:0] dec_data, pad_data_i, pad_ext_i, pad_data_o, img_y, img_c;
  logic dec_hs, dec_vs, dec_fld, pad_hs_i, pad_vs_i, pad_fld_i;
  logic pad_hs_o, pad_vs_o, pad_fld_o, pad_oe, port_is_input;
  logic img_valid, img_c_is_cr, img_fld;

  typedef struct packed {
    logic [7:0] y;
    logic [7:0] c;
    logic       sel;
    logic       fld;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  vexp_port i_vexp_port (
    .clk(clk), .rst_n(rst_n), .dir_req(dir_req), .embed_codes(embed_codes),
    .wide_in(wide_in), .dec_data(dec_data), .dec_hs(dec_hs), .dec_vs(dec_vs),
    .dec_fld(dec_fld), .pad_data_i(pad_data_i), .pad_ext_i(pad_ext_i),
    .pad_hs_i(pad_hs_i), .pad_vs_i(pad_vs_i), .pad_fld_i(pad_fld_i),
    .pad_data_o(pad_data_o), .pad_hs_o(pad_hs_o), .pad_vs_o(pad_vs_o),
    .pad_fld_o(pad_fld_o), .pad_oe(pad_oe), .port_is_input(port_is_input),
    .img_valid(img_valid), .img_y(img_y), .img_c(img_c),
    .img_c_is_cr(img_c_is_cr), .img_fld(img_fld)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drv(input logic [7:0] d, input logic [7:0] x, input logic h, input logic v);
    pad_data_i = d; pad_ext_i = x; pad_hs_i = h; pad_vs_i = v;
    tick();
  endtask

  task automatic push(input logic [7:0] y, input logic [7:0] c, input logic sel, input logic fld, input string tag);
    exp_q.push_back('{y: y, c: c, sel: sel, fld: fld});
    tag_q.push_back(tag);
  endtask

  // separate-sync 8-bit group: Cb, Y, Cr, Y
  task automatic line8(input logic [7:0] cb, input logic [7:0] y0, input logic [7:0] cr,
                       input logic [7:0] y1, input logic fld, input string tag);
    drv(cb, 8'h00, 1'b0, 1'b0);
    push(y0, cb, 1'b0, fld, tag);
    drv(y0, 8'h00, 1'b0, 1'b0);
    drv(cr, 8'h00, 1'b0, 1'b0);
    push(y1, cr, 1'b1, fld, tag);
    drv(y1, 8'h00, 1'b0, 1'b0);
  endtask

  // embedded timing: preamble then status byte, sync pins held inactive
  task automatic code(input logic [7:0] xy);
    drv(8'hFF, 8'h00, 1'b1, 1'b1);
    drv(8'h00, 8'h00, 1'b1, 1'b1);
    drv(8'h00, 8'h00, 1'b1, 1'b1);
    drv(xy, 8'h00, 1'b1, 1'b1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (img_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected item", {img_y, img_c}, 0);
      end else begin
        item_t e;
        item_t g;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = '{y: img_y, c: img_c, sel: img_c_is_cr, fld: img_fld};
        chk(g == e, t, g, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dir_req = 1'b0; embed_codes = 1'b0; wide_in = 1'b0;
    dec_data = 8'h00; dec_hs = 1'b0; dec_vs = 1'b0; dec_fld = 1'b0;
    pad_data_i = 8'h80; pad_ext_i = 8'h00; pad_hs_i = 1'b1; pad_vs_i = 1'b0; pad_fld_i = 1'b0;
    repeat (3) tick();
    chk(pad_oe == 1'b1, "R10 oe in reset", pad_oe, 1);
    chk(port_is_input == 1'b0, "R10 direction in reset", port_is_input, 0);
    chk(img_valid == 1'b0, "R10 no item in reset", img_valid, 0);
    rst_n = 1'b1;
    repeat (4) tick();

    // R4 output copies, two patterns
    dec_data = 8'h5A; dec_hs = 1'b1; #1;
    chk(pad_data_o == 8'h5A, "R4 data copy", pad_data_o, 8'h5A);
    chk(pad_hs_o == 1'b1, "R4 hsync copy", pad_hs_o, 1);
    dec_data = 8'hA5; dec_hs = 1'b0; dec_vs = 1'b1; #1;
    chk(pad_data_o == 8'hA5, "R4 data copy 2", pad_data_o, 8'hA5);
    chk(pad_vs_o == 1'b1, "R4 vsync copy", pad_vs_o, 1);
    dec_vs = 1'b0;
    tick();

    // R3 request without field edge does nothing
    dir_req = 1'b1;
    repeat (5) tick();
    chk(port_is_input == 1'b0, "R3 held until edge", port_is_input, 0);
    chk(pad_oe == 1'b1, "R5 oe held", pad_oe, 1);

    // R9 decoder field toggle switches to input, R5 oe falls with it
    dec_fld = 1'b1;
    tick();
    chk(port_is_input == 1'b1, "R9 switch at dec field edge", port_is_input, 1);
    chk(pad_oe == 1'b0, "R5 oe falls with switch", pad_oe, 0);
    chk(pad_fld_o == 1'b1, "R4 field copy", pad_fld_o, 1);

    // R1 R7 separate sync, 8-bit
    drv(8'h80, 8'h00, 1'b1, 1'b0);
    drv(8'h80, 8'h00, 1'b1, 1'b0);
    line8(8'h11, 8'h21, 8'h31, 8'h41, 1'b0, "R1 sep group A");
    line8(8'h12, 8'h22, 8'h32, 8'h42, 1'b0, "R1 sep group B");
    drv(8'h80, 8'h00, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) drv(8'h13, 8'h00, 1'b0, 1'b1); // R7 vsync blocks
    pad_fld_i = 1'b1;
    drv(8'h80, 8'h00, 1'b1, 1'b0);
    line8(8'h14, 8'h24, 8'h34, 8'h44, 1'b1, "R11 sep field 1");
    drv(8'h80, 8'h00, 1'b1, 1'b0);
    chk(port_is_input == 1'b1, "R3 edge with same request keeps input", port_is_input, 1);

    // R8 16-bit input
    wide_in = 1'b1;
    drv(8'h80, 8'h00, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      push(8'h50 + 8'(i), 8'h90 + 8'(i), 1'(i % 2), 1'b1, "R8 wide item");
      drv(8'h50 + 8'(i), 8'h90 + 8'(i), 1'b0, 1'b0);
    end
    drv(8'h80, 8'h00, 1'b1, 1'b0);
    wide_in = 1'b0;
    drv(8'h80, 8'h00, 1'b1, 1'b0);

    // R6 embedded timing, 8-bit
    embed_codes = 1'b1;
    drv(8'h10, 8'h00, 1'b1, 1'b1);
    code(8'h80);
    drv(8'h22, 8'h00, 1'b1, 1'b1);
    push(8'h33, 8'h22, 1'b0, 1'b0, "R6 embedded Cb item");
    drv(8'h33, 8'h00, 1'b1, 1'b1);
    drv(8'h44, 8'h00, 1'b1, 1'b1);
    push(8'h55, 8'h44, 1'b1, 1'b0, "R6 embedded Cr item");
    drv(8'h55, 8'h00, 1'b1, 1'b1);
    code(8'h90);
    drv(8'h10, 8'h00, 1'b1, 1'b1);
    code(8'hA0); // V=1: opens nothing
    for (int i = 0; i < 4; i++) drv(8'h40 + 8'(i), 8'h00, 1'b1, 1'b1);
    code(8'hB0);
    drv(8'h10, 8'h00, 1'b1, 1'b1);

    // R9 pad field pin ignored with embedded timing
    dir_req = 1'b0; pad_fld_i = 1'b0;
    repeat (3) drv(8'h10, 8'h00, 1'b1, 1'b1);
    chk(port_is_input == 1'b1, "R9 pin field ignored in embedded", port_is_input, 1);

    // F bit flips on a start code while output is requested
    code(8'hC0);
    chk(port_is_input == 1'b0, "R9 switch on F change", port_is_input, 0);
    chk(pad_oe == 1'b0, "R5 oe off on turnaround clock", pad_oe, 0);
    drv(8'h10, 8'h00, 1'b1, 1'b1);
    chk(pad_oe == 1'b1, "R5 oe on one clock later", pad_oe, 1);

    // R2 input activity in output mode produces no item
    embed_codes = 1'b0;
    for (int i = 0; i < 4; i++) begin
      drv(8'h66, 8'h00, 1'b0, 1'b0);
      chk(img_valid == 1'b0, "R2 no item in output mode", img_valid, 0);
    end
    dec_data = 8'hC3; #1;
    chk(pad_data_o == 8'hC3, "R4 copy after turnaround", pad_data_o, 8'hC3);
    drv(8'h66, 8'h00, 1'b1, 1'b0);

    // R3 request change on the same clock as the field edge
    dir_req = 1'b1; dec_fld = 1'b0;
    tick();
    chk(port_is_input == 1'b1, "R3 same-clock request honoured", port_is_input, 1);
    // R3 withdrawn request before edge
    dir_req = 1'b0; tick();
    dir_req = 1'b1;
    repeat (3) tick();
    pad_fld_i = 1'b1;
    tick();
    chk(port_is_input == 1'b1, "R3 withdrawn request ignored", port_is_input, 1);
    dir_req = 1'b0; pad_fld_i = 1'b0;
    tick();
    chk(port_is_input == 1'b0, "R9 pin field edge switches", port_is_input, 0);
    repeat (4) tick();

    chk(exp_q.size() == 0, "R1 items left unseen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule